// File: doc/BRIEF.md
# Serial Character Transmitter with Idle and Break Frames

This block turns parallel characters into an asynchronous serial stream on a single output line. Each character goes out as a low start bit, the data bits least significant first, an optional even-parity bit, and a stop period whose length can be one half, one, one and a half or two bit times. Bit timing comes from a one-cycle timing strobe `tick16` that pulses sixteen times per bit period. Baud-rate division happens outside this block.

When `tx_en` rises, the line first carries one idle frame: it stays high for the length of a whole character, stop period included, and only then does the block offer to take data. A rising edge on `brk_req` queues a break frame. A break drives the line low for a fixed number of bit times that depends on the word length, then high for exactly two bit times. A pending break wins over a pending character at the next frame boundary. If `tx_en` drops, the frame in progress is dropped, the line goes high, and the timing counters are cleared.

The controller is a state machine with these states: `S_OFF` (disabled, line high), `S_IDLE` (idle frame), `S_READY` (waiting for a character or break), `S_START`, `S_DATA`, `S_STOP`, `S_BRK_LOW` and `S_BRK_STOP`. Its transitions are:
- any state goes to `S_OFF` whenever `tx_en` is low;
- `S_OFF` goes to `S_IDLE` when `tx_en` is high;
- `S_IDLE` goes to `S_READY` at the end of the idle length;
- `S_READY` goes to `S_BRK_LOW` on a pending or new break, otherwise to `S_START` on a valid character;
- `S_START` goes to `S_DATA` after one bit;
- `S_DATA` goes to `S_STOP` after the last data bit;
- `S_STOP` goes to `S_READY` after the stop length;
- `S_BRK_LOW` goes to `S_BRK_STOP` after the low length;
- `S_BRK_STOP` goes to `S_READY` after two bits.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, and in any cycle that follows a clock edge at which `tx_en` was low, `txd` is 1 and `din_ready` is 0. A character offered while `tx_en` is low is never accepted.
- R2: After `tx_en` rises, `din_ready` stays 0 and `txd` stays 1 for exactly 16·(1+N)+S strobes. N is the word length and S is the stop length in strobes. Both are taken from `wlen_sel` and `stop_sel` at the moment of enabling.
- R3: After a character is accepted, `txd` is 0 for 16 strobes (start bit). It then carries character bit 0 first, bit N-1 last, with each bit lasting 16 strobes.
- R4: Word length N is set by `wlen_sel`: 00 gives 8 bits, 01 gives 9 bits, 10 gives 7 bits, and 11 gives 8 bits. The count includes the parity bit when parity is on.
- R5: With `par_en` set, bit N-1 on the line is the XOR of `din` bits 0 to N-2 (even parity). `din` bit N-1 is then not sent.
- R6: The stop period is high and is set by `stop_sel`: 00 gives 16 strobes, 01 gives 8, 10 gives 32 and 11 gives 24. `din_ready` returns in the cycle after the last stop strobe.
- R7: A break holds `txd` low for 16·(N+2) strobes (10, 11 or 9 bit times for `wlen_sel` 00, 01 or 10). It then holds `txd` high for 32 strobes, whatever `stop_sel` is.
- R8: A break is started only by a rising edge of `brk_req` while `tx_en` is high. Holding `brk_req` high produces exactly one break.
- R9: When a break edge or a queued break meets a waiting character, the break is sent first and the character follows it. `din_ready` is 0 in a cycle where `brk_req` rises with `tx_en` high.
- R10: Clearing `tx_en` in the middle of a frame returns `txd` high by the next cycle. The character is discarded and is not resumed after re-enabling.
- R11: `din_ready` is 1 only while the block waits between frames. The line is high whenever it is 1, and a character is taken on a cycle with `din_valid` and `din_ready` both high. Word length, stop length, parity and data are captured at that moment. Later changes on those inputs do not alter the frame in flight.
- R12: `txd` rises only on a clock edge at which `tick16` was high or `tx_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| wlen_sel | input | 2 | Word length select |
| stop_sel | input | 2 | Stop length select |
| par_en | input | 1 | Even parity enable |
| din | input | 9 | Character to send, bit 0 first |
| din_valid | input | 1 | Character offered |
| din_ready | output | 1 | Character can be taken this cycle |
| brk_req | input | 1 | Break request, edge triggered |
| tick16 | input | 1 | Timing strobe, 16 per bit |
| txd | output | 1 | Serial line |

## Verification
Every word length, stop length and parity setting is swept, and each frame's line is compared strobe by strobe against a computed expectation. An off-by-one stop length would show up as `din_ready` rising early or late. A parity bit placed wrong would show up as a bit mismatch. The bench changes the configuration inputs right after a character is accepted, so a design that reads them live corrupts the frame. Breaks are measured for each word length while `stop_sel` is set to one half bit, and then held for a long time. A design that re-arms on level would send a second break, and a design that uses the stop selection would shorten the high tail. A break and a character are raised together, and a design without break priority would start a start bit instead. Finally, `tx_en` is dropped while a zero data bit is on the line and data is offered while disabled. This catches a line that stays low, a character that is silently accepted, and a frame that resumes.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DW = 9;

    typedef enum logic [2:0] {
        S_OFF,
        S_IDLE,
        S_READY,
        S_START,
        S_DATA,
        S_STOP,
        S_BRK_LOW,
        S_BRK_STOP
    } tx_state_e;

    function automatic logic [3:0] nbits_of(input logic [1:0] sel);
        unique case (sel)
            2'b01:   return 4'd9;
            2'b10:   return 4'd7;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/uart_tx_timer.sv
module uart_tx_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] len,
    output logic          done
);

    logic [CW-1:0] phase;

    assign done = tick && !clear && (phase == len - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clear) begin
            phase <= '0;
        end else if (tick) begin
            phase <= done ? '0 : phase + CW'(1);
        end
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic [3:0]    nbits,
    input  logic          par_en,
    output logic [DW-1:0] word
);

    logic par_bit;

    always_comb begin
        par_bit = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nbits) - 1) par_bit = par_bit ^ data[i];
        end
        for (int i = 0; i < DW; i++) begin
            word[i] = (par_en && (i == int'(nbits) - 1)) ? par_bit : data[i];
        end
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [1:0]    wlen_sel,
    input  logic [1:0]    stop_sel,
    input  logic          par_en,
    input  logic [DW-1:0] din,
    input  logic          din_valid,
    output logic          din_ready,
    input  logic          brk_req,
    input  logic          tick16,
    output logic          txd
);

    localparam int CW = $clog2(OSR * (DW + 3) + 1);
    localparam logic [CW-1:0] BIT_T  = CW'(OSR);
    localparam logic [CW-1:0] HALF_T = CW'(OSR / 2);

    tx_state_e     state, state_nx;
    logic [3:0]    nb_q;
    logic [1:0]    stop_q;
    logic [DW-1:0] word_q, word_nx;
    logic [3:0]    bit_idx;
    logic          brk_q, brk_pend, brk_edge, brk_go;
    logic [CW-1:0] stop_t, seg_len;
    logic          seg_done, tmr_clear;

    assign brk_edge  = tx_en && brk_req && !brk_q;
    assign brk_go    = brk_pend || brk_edge;
    assign tmr_clear = (state == S_OFF) || (state == S_READY);

    uart_tx_framer u_framer (
        .data   (din),
        .nbits  (nbits_of(wlen_sel)),
        .par_en (par_en),
        .word   (word_nx)
    );

    uart_tx_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick16),
        .len   (seg_len),
        .done  (seg_done)
    );

    always_comb begin
        unique case (stop_q)
            2'b00:   stop_t = BIT_T;
            2'b01:   stop_t = HALF_T;
            2'b10:   stop_t = BIT_T + BIT_T;
            default: stop_t = BIT_T + HALF_T;
        endcase
    end

    always_comb begin
        unique case (state)
            S_IDLE:     seg_len = BIT_T * (CW'(nb_q) + CW'(1)) + stop_t;
            S_STOP:     seg_len = stop_t;
            S_BRK_LOW:  seg_len = BIT_T * (CW'(nb_q) + CW'(2));
            S_BRK_STOP: seg_len = BIT_T + BIT_T;
            default:    seg_len = BIT_T;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (!tx_en) begin
            state_nx = S_OFF;
        end else begin
            unique case (state)
                S_OFF:      state_nx = S_IDLE;
                S_IDLE:     if (seg_done) state_nx = S_READY;
                S_READY: begin
                    if (brk_go)         state_nx = S_BRK_LOW;
                    else if (din_valid) state_nx = S_START;
                end
                S_START:    if (seg_done) state_nx = S_DATA;
                S_DATA:     if (seg_done && bit_idx == nb_q - 4'd1) state_nx = S_STOP;
                S_STOP:     if (seg_done) state_nx = S_READY;
                S_BRK_LOW:  if (seg_done) state_nx = S_BRK_STOP;
                S_BRK_STOP: if (seg_done) state_nx = S_READY;
                default:    state_nx = S_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= state_nx;
    end

    // Frame capture, bit position and break queue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nb_q     <= 4'd8;
            stop_q   <= 2'b00;
            word_q   <= '0;
            bit_idx  <= '0;
            brk_q    <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            brk_q <= brk_req;
            if (!tx_en)                           brk_pend <= 1'b0;
            else if (state == S_READY && brk_go)  brk_pend <= 1'b0;
            else if (brk_edge)                    brk_pend <= 1'b1;

            if (state == S_OFF && tx_en) begin
                nb_q   <= nbits_of(wlen_sel);
                stop_q <= stop_sel;
            end else if (state == S_READY && tx_en) begin
                if (brk_go) begin
                    nb_q <= nbits_of(wlen_sel);
                end else if (din_valid) begin
                    nb_q   <= nbits_of(wlen_sel);
                    stop_q <= stop_sel;
                    word_q <= word_nx;
                end
            end

            if (state == S_START)                 bit_idx <= '0;
            else if (state == S_DATA && seg_done) bit_idx <= bit_idx + 4'd1;
        end
    end

    // Outputs
    always_comb begin
        din_ready = (state == S_READY) && tx_en && !brk_go;
        unique case (state)
            S_START, S_BRK_LOW: txd = 1'b0;
            S_DATA:             txd = word_q[bit_idx];
            default:            txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic brk_req,
    input logic din_valid,
    input logic din_ready,
    input logic tick16,
    input logic txd
);

    a_r1_off_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && !din_ready));

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (din_valid && din_ready) |=> !txd);

    a_r9_break_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && brk_req && !$past(brk_req)) |-> !din_ready);

    a_r11_ready_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> txd);

    a_r12_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txd) |-> ($past(tick16) || !$past(tx_en)));

endmodule

bind uart_tx_engine uart_tx_engine_chk u_chk (.*);

// File: tb/uart_tx_engine_test.sv
module uart_tx_engine_test;

    logic       clk = 1'b0;
    logic       rst_n, tx_en, par_en, din_valid, brk_req, tick16;
    logic [1:0] wlen_sel, stop_sel;
    logic [8:0] din;
    logic       din_ready, txd;
    int         n_chk = 0, n_fail = 0, tc = 0;

    always #5 clk = ~clk;

    uart_tx_engine uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wlen_sel(wlen_sel),
        .stop_sel(stop_sel), .par_en(par_en), .din(din), .din_valid(din_valid),
        .din_ready(din_ready), .brk_req(brk_req), .tick16(tick16), .txd(txd)
    );

    initial begin
        tick16 = 1'b0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 3;
            tick16 = (tc == 0);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int nb(input logic [1:0] w);
        return (w == 2'b01) ? 9 : (w == 2'b10) ? 7 : 8;
    endfunction

    function automatic int stops(input logic [1:0] s);
        return (s == 2'b00) ? 16 : (s == 2'b01) ? 8 : (s == 2'b10) ? 32 : 24;
    endfunction

    function automatic logic exp_bit(input int idx, input logic [8:0] d, input int n, input bit p);
        int b = idx / 16;
        logic par = 1'b0;
        if (b == 0) return 1'b0;
        if (b <= n) begin
            if (p && (b - 1 == n - 1)) begin
                for (int i = 0; i < n - 1; i++) par ^= d[i];
                return par;
            end
            return d[b-1];
        end
        return 1'b1;
    endfunction

    task automatic enable_idle(input logic [1:0] w, input logic [1:0] s);
        int cnt = 0, lows = 0;
        @(negedge clk);
        wlen_sel = w; stop_sel = s; tx_en = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (din_ready) break;
            if (txd !== 1'b1) lows++;
            if (tick16) cnt++;
        end
        check(cnt == 16 * (1 + nb(w)) + stops(s), "R2 idle length", cnt, 16 * (1 + nb(w)) + stops(s));
        check(lows == 0, "R2 idle line high", lows, 0);
    endtask

    task automatic offer(input logic [8:0] d, input logic [1:0] w, input logic [1:0] s, input bit p);
        din = d; wlen_sel = w; stop_sel = s; par_en = p; din_valid = 1'b1;
    endtask

    // R3 R4 R5 R6 R11: strobe-by-strobe comparison of one frame
    task automatic take_frame(input logic [8:0] d, input logic [1:0] w, input logic [1:0] s, input bit p);
        int n = nb(w);
        int total = 16 * (1 + n) + stops(s);
        int idx = 0, mism = 0, first = -1, rdy = 0;
        bit first_it = 1'b1;
        while (!din_ready) @(negedge clk);
        @(posedge clk);
        while (idx < total) begin
            @(negedge clk);
            if (first_it) begin
                din_valid = 1'b0; wlen_sel = ~w; stop_sel = ~s; par_en = ~p; din = ~d;
                first_it = 1'b0;
            end
            if (din_ready) rdy++;
            if (tick16) begin
                if (txd !== exp_bit(idx, d, n, p)) begin
                    mism++;
                    if (first < 0) first = idx;
                end
                idx++;
            end
        end
        check(mism == 0, "R3 R4 R5 frame bits, first bad strobe", first, -1);
        check(rdy == 0, "R6 R11 ready during frame", rdy, 0);
        @(negedge clk);
        check(din_ready == 1'b1, "R6 ready after stop", din_ready, 1);
    endtask

    task automatic measure_break(input int n);
        int lowc = 0, highc = 0;
        while (txd !== 1'b0) @(negedge clk);
        while (!din_ready) begin
            if (tick16) begin
                if (txd == 1'b0) lowc++;
                else             highc++;
            end
            @(negedge clk);
        end
        check(lowc == 16 * (n + 2), "R7 R9 break low strobes", lowc, 16 * (n + 2));
        check(highc == 32, "R7 break high strobes", highc, 32);
    endtask

    initial begin
        int lows, rdys;
        rst_n = 1'b0; tx_en = 1'b0; par_en = 1'b0; din_valid = 1'b0; brk_req = 1'b0;
        wlen_sel = 2'b00; stop_sel = 2'b00; din = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R1 reset line", txd, 1);
        check(din_ready == 1'b0, "R1 reset ready", din_ready, 0);

        // R1: data offered while disabled is not taken
        din_valid = 1'b1; rdys = 0; lows = 0;
        repeat (40) begin
            @(negedge clk);
            if (din_ready) rdys++;
            if (!txd) lows++;
        end
        din_valid = 1'b0;
        check(rdys == 0, "R1 ready while disabled", rdys, 0);
        check(lows == 0, "R1 line while disabled", lows, 0);

        enable_idle(2'b00, 2'b00);

        // Sweep of every word length, stop length and parity setting
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 4; s++)
                for (int p = 0; p < 2; p++) begin
                    logic [8:0] d = 9'h15A ^ 9'((w * 8 + s * 2 + p) * 77);
                    @(negedge clk);
                    offer(d, 2'(w), 2'(s), p[0]);
                    take_frame(d, 2'(w), 2'(s), p[0]);
                end

        // R7 R8: break per word length, request held long
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            wlen_sel = 2'(w); stop_sel = 2'b01; brk_req = 1'b1;
            measure_break(nb(2'(w)));
            lows = 0; rdys = 0;
            repeat (150) begin
                @(negedge clk);
                if (!txd) lows++;
                if (din_ready) rdys++;
            end
            check(lows == 0, "R8 no second break", lows, 0);
            check(rdys == 150, "R8 ready while held", rdys, 150);
            brk_req = 1'b0;
            @(negedge clk);
        end

        // R9: break and character raised together
        @(negedge clk);
        offer(9'h0FF, 2'b00, 2'b00, 1'b0);
        brk_req = 1'b1;
        measure_break(8);
        take_frame(9'h0FF, 2'b00, 2'b00, 1'b0);
        brk_req = 1'b0;

        // R10: disable while a zero data bit is on the line
        @(negedge clk);
        offer(9'h000, 2'b00, 2'b00, 1'b0);
        while (!din_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        din_valid = 1'b0;
        repeat (59) @(negedge clk);
        check(txd == 1'b0, "R10 mid-frame bit low before disable", txd, 0);
        tx_en = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R10 line high after disable", txd, 1);
        check(din_ready == 1'b0, "R10 ready after disable", din_ready, 0);
        din_valid = 1'b1; lows = 0; rdys = 0;
        repeat (60) begin
            @(negedge clk);
            if (!txd) lows++;
            if (din_ready) rdys++;
        end
        din_valid = 1'b0;
        check(lows == 0, "R10 R1 line stays high", lows, 0);
        check(rdys == 0, "R1 no acceptance while disabled", rdys, 0);
        enable_idle(2'b10, 2'b01);
        @(negedge clk);
        offer(9'h0A3, 2'b10, 2'b01, 1'b1);
        take_frame(9'h0A3, 2'b10, 2'b01, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule